// File: doc/BRIEF.md
# Clock-chip register file with update sequencing and interrupt flags

This block is the host-facing side of a real-time clock. A host reaches a 128-byte register space through two addresses: a write to the even address loads a pointer, and reads or writes at the odd address act on the byte that pointer selects. Four bytes of the space are control registers. Here they are named mode (index 10), config (index 11), flags (index 12) and status (index 13). The remaining bytes are plain storage, apart from seven time bytes, which an update refreshes, and three alarm bytes.

The calendar arithmetic and the periodic-rate divider live outside the block. When a one-second tick arrives and the oscillator field of the mode register selects normal running, the block pulses `calAdvance` and raises the read-only busy bit. It then waits a fixed number of slow-clock ticks, copies the calendar's fields into the time bytes, compares the alarm bytes and posts flags. The flag register clears when it is read. The interrupt line is the flag register's summary bit.

Top module: `rtc_regfile_irq`

## Requirements
- R1: A write to the even address (`busAddr`=0) stores the low 7 bits of the data as the pointer, so 0x80 is dropped from the value written. A read of the even address returns 0xFF.
- R2: Odd-address accesses to any pointer value outside 10..13 store and return a full byte. This includes the alarm bytes at indices 1 (seconds), 3 (minutes) and 5 (hours).
- R3: Mode register bit 7 (busy) cannot be written by the host. A write to the mode register updates bits 6:0 and leaves bit 7 as it was.
- R4: A config write with bit 7 (freeze) set clears mode bit 7 at once, and the config register stores bit 4 (update-ended enable) as 0.
- R5: Writes to the flag register and the status register have no effect. The status register always reads 0x80.
- R6: A read of the flag register returns its current value, and the register is 0 from the next cycle. Any flag raised in that same cycle is kept.
- R7: A one-second tick with mode bits 6:4 = 010 pulses `calAdvance` in the same cycle and sets mode bit 7 (unless freeze is set). Bit 7 stays set until the UIP_HOLD-th slow tick. At that tick it clears, and `calTime` bytes 0..6 are copied to time indices 0, 2, 4, 6, 7, 8, 9.
- R8: A one-second tick while mode bits 6:4 differ from 010 does nothing: no `calAdvance`, no busy bit, no copy.
- R9: At the end of an update with config bit 5 (alarm enable) set, the alarm fires when each of the three alarm bytes either has bits 7:6 = 11 or equals the matching `calTime` byte (0 seconds, 1 minutes, 2 hours). A firing alarm ORs 0xA0 into the flag register.
- R10: At the end of an update with config bit 4 set, 0x90 is ORed into the flag register.
- R11: A `perTick` pulse ORs 0xC0 into the flag register only when config bit 6 is set.
- R12: After `rstN`, mode = 0x26, config = 0x02, flags = 0x00 and status = 0x80. A `warmRst` pulse clears config bits 6, 5 and 3 and the whole flag register, and leaves the other config bits unchanged.
- R13: `irq` equals flag bit 7. It stays high until a flag read or a warm reset.
- R14: While freeze is set, an update still pulses `calAdvance` but leaves the time bytes unchanged and does not set the busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| warmRst | input | 1 | Synchronous warm reset pulse |
| busWr | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe (triggers read side effects) |
| busAddr | input | 1 | 0 = pointer address, 1 = data address |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data (combinational) |
| secTick | input | 1 | One-second tick from the divider |
| slowTick | input | 1 | Slow-clock enable used to time the busy hold |
| perTick | input | 1 | Periodic-rate tick from the divider |
| calTime | input | 56 | Calendar fields, byte 0 seconds through byte 6 year |
| calAdvance | output | 1 | Pulse asking the calendar to step one second |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench builds the block with IDX_W = 7, which keeps the full 128-byte space. With that width, pointer writes carrying bit 7 set test the masking, and random traffic can reach every plain byte. UIP_HOLD is set to 4 instead of 8, so every directed update fits into a handful of slow ticks. That makes it practical to observe the busy bit on the tick before it clears, to have freeze land partway through a hold, and to run alarm and update-ended flags back to back.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;

  // control register pointers
  localparam int MODE_IDX = 10;
  localparam int CFG_IDX  = 11;
  localparam int FLAG_IDX = 12;
  localparam int STAT_IDX = 13;

  localparam logic [7:0] MODE_RST = 8'h26;
  localparam logic [7:0] CFG_RST  = 8'h02;
  localparam logic [7:0] STAT_VAL = 8'h80;

  localparam int TIME_FIELDS  = 7;
  localparam int ALARM_FIELDS = 3;

  // flag patterns
  localparam logic [7:0] FLG_PERIODIC = 8'hC0;
  localparam logic [7:0] FLG_ALARM    = 8'hA0;
  localparam logic [7:0] FLG_UPDEND   = 8'h90;

  // config bits cleared by warm reset: periodic, alarm, square-wave enables
  localparam logic [7:0] CFG_WARM_KEEP = 8'h97;

  typedef struct packed {
    logic startUpd;
    logic endUpd;
  } updStrobe_t;

  // time field k -> register index
  function automatic int timeIdx(input int k);
    return (k < 3) ? 2 * k : k + 3;
  endfunction

endpackage

// File: rtl/rtcr_update_ctrl.sv
module rtcr_update_ctrl
  import rtcr_pkg::*;
#(
  parameter int UIP_HOLD = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       slowTick,
  input  logic       oscOk,
  output updStrobe_t strb
);

  localparam int CNT_W = $clog2(UIP_HOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UIP_HOLD - 1);

  typedef enum logic {UPD_IDLE, UPD_HOLD} updState_e;

  updState_e        state;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    strb.startUpd = (state == UPD_IDLE) && secTick && oscOk;
    strb.endUpd   = (state == UPD_HOLD) && slowTick && (holdCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= UPD_IDLE;
      holdCnt <= '0;
    end else begin
      case (state)
        UPD_IDLE: if (strb.startUpd) begin
          state   <= UPD_HOLD;
          holdCnt <= '0;
        end
        UPD_HOLD: if (slowTick) begin
          if (holdCnt == CNT_LAST) state <= UPD_IDLE;
          else holdCnt <= holdCnt + 1'b1;
        end
        default: state <= UPD_IDLE;
      endcase
    end
  end

  // R8: a tick with the oscillator field off leaves the sequencer idle
  p_skip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == UPD_IDLE && secTick && !oscOk) |=> (state == UPD_IDLE));

  // R7: the closing strobe always returns the sequencer to idle
  p_end_returns_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.endUpd |=> (state == UPD_IDLE));

endmodule

// File: rtl/rtcr_regs_dp.sv
module rtcr_regs_dp
  import rtcr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       warmRst,
  input  logic                       busWr,
  input  logic                       busRd,
  input  logic                       busAddr,
  input  logic [7:0]                 busWdata,
  output logic [7:0]                 busRdata,
  input  logic                       perTick,
  input  logic [8*TIME_FIELDS-1:0]   calTime,
  input  updStrobe_t                 strb,
  output logic                       oscOk,
  output logic                       irq
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] P_MODE = IDX_W'(MODE_IDX);
  localparam logic [IDX_W-1:0] P_CFG  = IDX_W'(CFG_IDX);
  localparam logic [IDX_W-1:0] P_FLAG = IDX_W'(FLAG_IDX);
  localparam logic [IDX_W-1:0] P_STAT = IDX_W'(STAT_IDX);

  logic [IDX_W-1:0] idxQ;
  logic [7:0]       mem [DEPTH];
  logic [7:0]       modeQ, cfgQ, flagQ;

  logic wrIdx, wrData, wrMode, wrCfg, rdFlag, isCtl;
  logic [ALARM_FIELDS-1:0] alMatch;
  logic alarmHit;
  logic [7:0] setFlags;

  assign wrIdx  = busWr && !busAddr;
  assign wrData = busWr && busAddr;
  assign isCtl  = (idxQ >= P_MODE) && (idxQ <= P_STAT);
  assign wrMode = wrData && (idxQ == P_MODE);
  assign wrCfg  = wrData && (idxQ == P_CFG);
  assign rdFlag = busRd && busAddr && (idxQ == P_FLAG);
  assign oscOk  = (modeQ[6:4] == 3'b010);

  // alarm comparators, one per field
  for (genvar f = 0; f < ALARM_FIELDS; f++) begin : g_alarm
    localparam logic [IDX_W-1:0] AL_IDX = IDX_W'(2 * f + 1);
    assign alMatch[f] = (mem[AL_IDX][7:6] == 2'b11) ||
                        (mem[AL_IDX] == calTime[8*f +: 8]);
  end
  assign alarmHit = &alMatch;

  always_comb begin
    setFlags = 8'h00;
    if (perTick && cfgQ[6])                   setFlags = setFlags | FLG_PERIODIC;
    if (strb.endUpd && cfgQ[5] && alarmHit)   setFlags = setFlags | FLG_ALARM;
    if (strb.endUpd && cfgQ[4])               setFlags = setFlags | FLG_UPDEND;
  end

  // pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxQ <= '0;
    else if (wrIdx) idxQ <= busWdata[IDX_W-1:0];
  end

  // plain storage and time bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      if (wrData && !isCtl) mem[idxQ] <= busWdata;
      if (strb.endUpd && !cfgQ[7]) begin
        for (int k = 0; k < TIME_FIELDS; k++)
          mem[IDX_W'(timeIdx(k))] <= calTime[8*k +: 8];
      end
    end
  end

  // mode register: busy bit owned by the sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RST;
    else begin
      if (wrMode) modeQ[6:0] <= busWdata[6:0];
      if (strb.startUpd && !cfgQ[7]) modeQ[7] <= 1'b1;
      if (strb.endUpd || (wrCfg && busWdata[7])) modeQ[7] <= 1'b0;
    end
  end

  // config register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= CFG_RST;
    else if (wrCfg) cfgQ <= busWdata[7] ? (busWdata & 8'hEF) : busWdata;
    else if (warmRst) cfgQ <= cfgQ & CFG_WARM_KEEP;
  end

  // flag register, read to clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 8'h00;
    else if (warmRst) flagQ <= 8'h00;
    else flagQ <= (rdFlag ? 8'h00 : flagQ) | setFlags;
  end

  assign irq = flagQ[7];

  always_comb begin
    if (!busAddr) busRdata = 8'hFF;
    else begin
      case (idxQ)
        P_MODE:  busRdata = modeQ;
        P_CFG:   busRdata = cfgQ;
        P_FLAG:  busRdata = flagQ;
        P_STAT:  busRdata = STAT_VAL;
        default: busRdata = mem[idxQ];
      endcase
    end
  end

  // R4: freeze write drops busy and the update-ended enable
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCfg && busWdata[7]) |=> (!modeQ[7] && !cfgQ[4]));

  // R6: a flag read with nothing new pending leaves the register empty
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlag && setFlags == 8'h00) |=> (flagQ == 8'h00));

  // R13: interrupt is held until a flag read or warm reset
  p_irq_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !rdFlag && !warmRst) |=> irq);

  // R7: busy only rises on a start strobe
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ[7]) |-> $past(strb.startUpd));

  // R3: host mode writes never raise busy
  p_mode_ro_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrMode && !modeQ[7] && !strb.startUpd) |=> !modeQ[7]);

endmodule

// File: rtl/rtc_regfile_irq.sv
module rtc_regfile_irq
  import rtcr_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int UIP_HOLD = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        warmRst,
  input  logic        busWr,
  input  logic        busRd,
  input  logic        busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        secTick,
  input  logic        slowTick,
  input  logic        perTick,
  input  logic [55:0] calTime,
  output logic        calAdvance,
  output logic        irq
);

  updStrobe_t strb;
  logic       oscOk;

  rtcr_update_ctrl #(.UIP_HOLD(UIP_HOLD)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .slowTick (slowTick),
    .oscOk    (oscOk),
    .strb     (strb)
  );

  rtcr_regs_dp #(.IDX_W(IDX_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .warmRst  (warmRst),
    .busWr    (busWr),
    .busRd    (busRd),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .perTick  (perTick),
    .calTime  (calTime),
    .strb     (strb),
    .oscOk    (oscOk),
    .irq      (irq)
  );

  assign calAdvance = strb.startUpd;

endmodule

// File: tb/rtc_regfile_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_regfile_irq_tb_top;

  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic warmRst = 1'b0, busWr = 1'b0, busRd = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic secTick = 1'b0, slowTick = 1'b0, perTick = 1'b0;
  logic [55:0] calTime = 56'h24_06_15_03_13_45_30;
  logic calAdvance, irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  rtc_regfile_irq #(.IDX_W(7), .UIP_HOLD(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .secTick(secTick), .slowTick(slowTick), .perTick(perTick),
    .calTime(calTime), .calAdvance(calAdvance), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] calByte(input int k);
    return calTime[8*k +: 8];
  endfunction

  task automatic busWrite(input logic a, input logic [7:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic busRead(input logic a, output logic [7:0] d);
    @(negedge clk); busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] d);
    busWrite(1'b0, idx); busWrite(1'b1, d);
  endtask

  task automatic regRead(input logic [7:0] idx, output logic [7:0] d);
    busWrite(1'b0, idx); busRead(1'b1, d);
  endtask

  task automatic pulseSec(output logic adv);
    @(negedge clk); secTick = 1; #1 adv = calAdvance;
    @(posedge clk); #1 secTick = 0;
  endtask

  task automatic pulseSlow();
    @(negedge clk); slowTick = 1;
    @(posedge clk); #1 slowTick = 0;
  endtask

  task automatic pulsePer();
    @(negedge clk); perTick = 1;
    @(posedge clk); #1 perTick = 0;
  endtask

  task automatic pulseWarm();
    @(negedge clk); warmRst = 1;
    @(posedge clk); #1 warmRst = 0;
  endtask

  task automatic fullUpdate();
    logic adv;
    pulseSec(adv);
    for (int i = 0; i < HOLD; i++) pulseSlow();
  endtask

  task automatic checkTime(input string tag, input logic [55:0] exp);
    logic [7:0] v;
    for (int k = 0; k < 7; k++) begin
      regRead(8'((k < 3) ? 2 * k : k + 3), v);
      chk(tag, v, exp[8*k +: 8]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (nChecks >= 0 && $time > 400000 && !finished) begin
        finished = 1;
        nFails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    logic adv;
    logic [55:0] oldTime;
    void'($urandom(32'd7351));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R12 reset state, R13 irq low
    regRead(8'd10, v); chk("R12 mode reset", v, 8'h26);
    regRead(8'd11, v); chk("R12 cfg reset", v, 8'h02);
    regRead(8'd12, v); chk("R12 flag reset", v, 8'h00);
    regRead(8'd13, v); chk("R5 status value", v, 8'h80);
    chk("R13 irq after reset", {7'd0, irq}, 8'h00);

    // R1 even read, pointer masking
    busRead(1'b0, v); chk("R1 even read", v, 8'hFF);
    regWrite(8'd40, 8'h5A);
    regRead(8'hA8, v); chk("R1 pointer drops bit 7", v, 8'h5A);
    model[40] = 8'h5A;

    // R2 random byte traffic
    for (int n = 0; n < 60; n++) begin
      int idx;
      logic [7:0] d;
      idx = $urandom % 128;
      if (idx >= 10 && idx <= 13) idx += 4;
      d = 8'($urandom);
      busWrite(1'b0, 8'(idx) | ($urandom % 2 ? 8'h80 : 8'h00));
      busWrite(1'b1, d);
      model[idx] = d;
    end
    for (int n = 0; n < 40; n++) begin
      int idx;
      idx = $urandom % 128;
      if (idx >= 10 && idx <= 13) idx += 4;
      regRead(8'(idx), v); chk("R2 random readback", v, model[idx]);
    end

    // R3 random mode writes keep bit 7
    for (int n = 0; n < 8; n++) begin
      logic [7:0] d;
      d = 8'($urandom) | 8'h80;
      regWrite(8'd10, d);
      busRead(1'b1, v); chk("R3 busy not writable", v, {1'b0, d[6:0]});
    end
    regWrite(8'd10, 8'h26);

    // R5 flag and status ignore writes
    regWrite(8'd12, 8'hFF); regRead(8'd12, v); chk("R5 flag ignores write", v, 8'h00);
    chk("R5 irq after flag write", {7'd0, irq}, 8'h00);
    regWrite(8'd13, 8'h00); regRead(8'd13, v); chk("R5 status ignores write", v, 8'h80);

    // R7 normal update with busy window and copy
    regWrite(8'd1, 8'h00); regWrite(8'd3, 8'h00); regWrite(8'd5, 8'h00);
    busWrite(1'b0, 8'd10);
    pulseSec(adv); chk("R7 calAdvance pulse", {7'd0, adv}, 8'h01);
    busRead(1'b1, v); chk("R7 busy set", v, 8'hA6);
    for (int i = 0; i < HOLD - 1; i++) pulseSlow();
    busRead(1'b1, v); chk("R7 busy held before last tick", v, 8'hA6);
    pulseSlow();
    busRead(1'b1, v); chk("R7 busy cleared", v, 8'h26);
    checkTime("R7 time copied", calTime);
    regRead(8'd12, v); chk("R10 no flags without enables", v, 8'h00);

    // R8 oscillator off: tick ignored
    oldTime = calTime;
    calTime = 56'h25_07_16_04_14_46_31;
    regWrite(8'd10, 8'h06);
    pulseSec(adv); chk("R8 no calAdvance", {7'd0, adv}, 8'h00);
    busRead(1'b1, v); chk("R8 busy stays low", v, 8'h06);
    for (int i = 0; i < HOLD; i++) pulseSlow();
    checkTime("R8 time unchanged", oldTime);
    regWrite(8'd10, 8'h26);

    // R9 alarm match with don't-care bytes
    regWrite(8'd1, calByte(0)); regWrite(8'd3, 8'hC0); regWrite(8'd5, 8'hFF);
    regWrite(8'd11, 8'h22);
    fullUpdate();
    chk("R13 irq on alarm", {7'd0, irq}, 8'h01);
    regRead(8'd12, v); chk("R9 alarm flags", v, 8'hA0);
    // R9 mismatch on seconds
    regWrite(8'd1, calByte(0) + 8'd1);
    fullUpdate();
    regRead(8'd12, v); chk("R9 alarm mismatch", v, 8'h00);
    // R9 exact hour match
    regWrite(8'd1, 8'hC0); regWrite(8'd5, calByte(2));
    fullUpdate();
    regRead(8'd12, v); chk("R9 exact hour match", v, 8'hA0);

    // R10 update-ended, R13 hold, R6 read clear
    regWrite(8'd11, 8'h12);
    fullUpdate();
    repeat (5) @(posedge clk);
    #1 chk("R13 irq held", {7'd0, irq}, 8'h01);
    regRead(8'd12, v); chk("R10 update-ended flags", v, 8'h90);
    #1 chk("R6 irq dropped after read", {7'd0, irq}, 8'h00);
    busRead(1'b1, v); chk("R6 flag cleared", v, 8'h00);
    // both
    regWrite(8'd11, 8'h32);
    fullUpdate();
    regRead(8'd12, v); chk("R10 alarm plus update-ended", v, 8'hB0);

    // R11 periodic
    regWrite(8'd11, 8'h42);
    pulsePer();
    regRead(8'd12, v); chk("R11 periodic flags", v, 8'hC0);
    regWrite(8'd11, 8'h02);
    pulsePer();
    regRead(8'd12, v); chk("R11 periodic disabled", v, 8'h00);

    // R4 freeze during busy hold, R14 freeze skips copy
    oldTime = calTime;
    calTime = 56'h26_08_17_05_15_47_32;
    busWrite(1'b0, 8'd10);
    pulseSec(adv);
    pulseSlow();
    busRead(1'b1, v); chk("R7 busy mid hold", v, 8'hA6);
    regWrite(8'd11, 8'h92);
    busRead(1'b1, v); chk("R4 freeze stores without bit 4", v, 8'h82);
    regRead(8'd10, v); chk("R4 busy cleared by freeze", v, 8'h26);
    for (int i = 0; i < HOLD - 1; i++) pulseSlow();
    checkTime("R14 no copy while frozen", oldTime);
    busWrite(1'b0, 8'd10);
    pulseSec(adv); chk("R14 calAdvance while frozen", {7'd0, adv}, 8'h01);
    busRead(1'b1, v); chk("R14 no busy while frozen", v, 8'h26);
    for (int i = 0; i < HOLD; i++) pulseSlow();
    checkTime("R14 still no copy", oldTime);
    regWrite(8'd11, 8'h02);

    // R12 warm reset
    regWrite(8'd11, 8'h6A);
    pulsePer();
    chk("R13 irq from periodic", {7'd0, irq}, 8'h01);
    pulseWarm();
    #1 chk("R12 irq cleared by warm reset", {7'd0, irq}, 8'h00);
    regRead(8'd11, v); chk("R12 warm reset cfg", v, 8'h02);
    regRead(8'd12, v); chk("R12 warm reset flags", v, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule